// File: doc/BRIEF.md
# Sector Byte-Error Correction Applier

This block finishes the read path of a 512-byte storage sector protected by a 4-bit multi-error code. An upstream decoder has already computed the error locations. It hands over a 3-bit count code and up to four pairs, each made of a location and an XOR pattern. The sector itself sits in a single-port byte RAM next to the block.

On `start`, the block decodes the count code. If the code says the sector is clean or uncorrectable, it answers at once. Otherwise it walks the supplied pairs in index order. For each pair it maps the reported location to a byte offset, which counts backwards from 0x207. It then reads that byte, XORs in the pattern and writes the byte back.

A location that maps outside the 512 payload bytes points into the parity bytes. Such a pair is counted as handled, but the RAM is not touched for it. When all pairs are done, a one-cycle `done` pulse reports the outcome on `pass`.

Top module: `ecc_fix_applier`

## Requirements
- R1: While `rst` is high and after it falls, `busy`, `done`, `pass`, `ram_en` and `ram_we` are low until a start is accepted.
- R2: Count code 4 means a clean sector. One cycle after `start`, `done` pulses with `pass`=1, and the RAM is not accessed.
- R3: Count code 7 means an uncorrectable sector. One cycle after `start`, `done` pulses with `pass`=0, and the RAM is not accessed.
- R4: Count codes 5 and 6 cannot be served with four pairs and are treated as uncorrectable: `done` pulses after one cycle with `pass`=0 and there are no RAM accesses.
- R5: A count code N from 0 to 3 applies pairs 0 through N in index order. Pairs above N have no effect on the buffer.
- R6: Pair i occupies bits [10*i+9:10*i] of `err_loc` and bits [8*i+7:8*i] of `err_pat`. Its byte offset is 0x207 minus the location, and the byte at that offset is XORed with the pattern.
- R7: A location whose offset falls outside 0..511 (location below 8 or above 0x207) is skipped without any RAM access. It takes one cycle and still counts as applied.
- R8: Each applied pair makes a read cycle (`ram_en`=1, `ram_we`=0) and, in the next cycle, a write cycle to the same address. The RAM returns read data one cycle after a read.
- R9: After a correcting start, `busy` stays high for 2 cycles per applied pair plus 1 per skipped pair. `done` then pulses for one cycle with `pass`=1, in the cycle in which `busy` falls.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing one decoder result |
| err_code | input | 3 | Error-count code from the decoder status |
| err_loc | input | 40 | Four 10-bit error locations, pair 0 in the low bits |
| err_pat | input | 32 | Four 8-bit XOR patterns, pair 0 in the low bits |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 9 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after a read |
| busy | output | 1 | Corrections in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Outcome, valid while done is high |

## Verification
For clean and failing codes, `done` is due on the first falling edge after the start edge. For a correcting code, it is due 2·(applied pairs) + (skipped pairs) + 1 falling edges after that start edge. The bench works this latency out from the locations it chose and counts falling edges until `done` appears. At each of those edges it also checks that `busy` is high, and it tallies the cycles with `ram_en` high against twice the number of applied pairs. Buffer contents are compared byte by byte with the bench's own golden image once `done` has been seen, before the next stimulus.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int          CODE_W     = 3;
  localparam logic [2:0]  CODE_CLEAN = 3'd4;
  localparam logic [2:0]  CODE_FAIL  = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } fix_state_t;
endpackage

// File: rtl/ecc_loc_map.sv
// Maps each reported error location to a sector byte offset and flags
// locations that fall in the parity bytes (outside the payload).
module ecc_loc_map #(
  parameter int SLOTS        = 4,
  parameter int LOC_W        = 10,
  parameter int SECTOR_BYTES = 512,
  parameter int REV_BASE     = 'h207,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic [SLOTS-1:0][LOC_W-1:0]  loc,
  output logic [SLOTS-1:0][ADDR_W-1:0] offset,
  output logic [SLOTS-1:0]             in_payload
);
  localparam logic [LOC_W:0] BASE  = (LOC_W+1)'(REV_BASE);
  localparam logic [LOC_W:0] LIMIT = (LOC_W+1)'(SECTOR_BYTES);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [LOC_W:0] loc_ext;
    logic [LOC_W:0] diff;
    assign loc_ext       = {1'b0, loc[g]};
    assign diff          = BASE - loc_ext;
    assign in_payload[g] = (loc_ext <= BASE) && (diff < LIMIT);
    assign offset[g]     = diff[ADDR_W-1:0];
  end
endmodule

// File: rtl/ecc_fix_ctrl.sv
// Sequencer: decodes the count code, then read-modify-writes one byte per
// applied pair through the single RAM port.
module ecc_fix_ctrl
  import ecc_fix_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [CODE_W-1:0]              code,
  input  logic [SLOTS-1:0][ADDR_W-1:0]   offset,
  input  logic [SLOTS-1:0]               in_payload,
  input  logic [SLOTS-1:0][DATA_W-1:0]   pattern,
  input  logic [DATA_W-1:0]              ram_rdata,
  output logic                           ram_en,
  output logic                           ram_we,
  output logic [ADDR_W-1:0]              ram_addr,
  output logic [DATA_W-1:0]              ram_wdata,
  output logic                           busy,
  output logic                           done,
  output logic                           pass
);
  fix_state_t                   state_q;
  logic [IDX_W-1:0]             idx_q;
  logic [IDX_W-1:0]             last_q;
  logic [SLOTS-1:0][ADDR_W-1:0] off_q;
  logic [SLOTS-1:0]             vld_q;
  logic [SLOTS-1:0][DATA_W-1:0] pat_q;
  logic                         step;
  logic                         correctable;

  assign correctable = (int'(code) < SLOTS);

  // A pair is finished after its write, or at once when it is skipped.
  assign step = (state_q == ST_WRITE) ||
                ((state_q == ST_READ) && !vld_q[idx_q]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      off_q   <= '0;
      vld_q   <= '0;
      pat_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (code == CODE_CLEAN) begin
              done <= 1'b1;
              pass <= 1'b1;
            end else if (correctable) begin
              off_q   <= offset;
              vld_q   <= in_payload;
              pat_q   <= pattern;
              last_q  <= code[IDX_W-1:0];
              idx_q   <= '0;
              busy    <= 1'b1;
              state_q <= ST_READ;
            end else begin
              done <= 1'b1;
              pass <= 1'b0;
            end
          end
        end
        ST_READ: begin
          if (vld_q[idx_q]) state_q <= ST_WRITE;
        end
        default: ;
      endcase

      if (step) begin
        if (idx_q == last_q) begin
          state_q <= ST_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
          pass    <= 1'b1;
        end else begin
          idx_q   <= idx_q + 1'b1;
          state_q <= ST_READ;
        end
      end
    end
  end

  always_comb begin
    ram_en    = ((state_q == ST_READ) && vld_q[idx_q]) || (state_q == ST_WRITE);
    ram_we    = (state_q == ST_WRITE);
    ram_addr  = off_q[idx_q];
    ram_wdata = ram_rdata ^ pat_q[idx_q];
  end
endmodule

// File: rtl/ecc_fix_applier.sv
module ecc_fix_applier
  import ecc_fix_pkg::*;
#(
  parameter int SLOTS        = 4,
  parameter int LOC_W        = 10,
  parameter int DATA_W       = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int REV_BASE     = 'h207,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [CODE_W-1:0]        err_code,
  input  logic [SLOTS*LOC_W-1:0]   err_loc,
  input  logic [SLOTS*DATA_W-1:0]  err_pat,
  output logic                     ram_en,
  output logic                     ram_we,
  output logic [ADDR_W-1:0]        ram_addr,
  output logic [DATA_W-1:0]        ram_wdata,
  input  logic [DATA_W-1:0]        ram_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     pass
);
  logic [SLOTS-1:0][LOC_W-1:0]  loc_a;
  logic [SLOTS-1:0][DATA_W-1:0] pat_a;
  logic [SLOTS-1:0][ADDR_W-1:0] offset;
  logic [SLOTS-1:0]             in_payload;

  assign loc_a = err_loc;
  assign pat_a = err_pat;

  ecc_loc_map #(
    .SLOTS(SLOTS), .LOC_W(LOC_W),
    .SECTOR_BYTES(SECTOR_BYTES), .REV_BASE(REV_BASE)
  ) u_map (
    .loc(loc_a), .offset(offset), .in_payload(in_payload)
  );

  ecc_fix_ctrl #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .code(err_code),
    .offset(offset), .in_payload(in_payload), .pattern(pat_a),
    .ram_rdata(ram_rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata),
    .busy(busy), .done(done), .pass(pass)
  );
endmodule

// File: rtl/ecc_fix_applier_chk.sv
module ecc_fix_applier_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        err_code,
  input logic              ram_en,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              busy,
  input logic              done,
  input logic              pass
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !ram_en && !ram_we));

  // R2
  clean_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && err_code == 3'd4) |=> (done && pass && !ram_en));

  // R3
  fail_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && err_code == 3'd7) |=> (done && !pass && !ram_en));

  // R8
  write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(ram_en) && !$past(ram_we) && ram_addr == $past(ram_addr)));

  // R8
  write_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_en);

  // R9
  access_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ram_en |-> busy);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_ends_in_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind ecc_fix_applier ecc_fix_applier_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .err_code(err_code),
  .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
  .busy(busy), .done(done), .pass(pass)
);

// File: tb/ecc_fix_applier_test.sv
module ecc_fix_applier_test;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  err_code = '0;
  logic [39:0] err_loc = '0;
  logic [31:0] err_pat = '0;
  logic        ram_en, ram_we;
  logic [8:0]  ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic        busy, done, pass;

  logic [7:0]  mem  [NBYTES];
  logic [7:0]  gold [NBYTES];

  int checks = 0;
  int fails  = 0;
  bit poke_start = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_fix_applier uut (
    .clk(clk), .rst(rst), .start(start), .err_code(err_code),
    .err_loc(err_loc), .err_pat(err_pat),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .busy(busy), .done(done), .pass(pass)
  );

  // Bench model of the single-port sector RAM, one-cycle read latency
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        ram_rdata     <= mem[ram_addr];
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [9:0] loc_of(input int off);
    return 10'(32'h207 - off);
  endfunction

  task automatic fill_random();
    for (int i = 0; i < NBYTES; i++) begin
      gold[i] = 8'($urandom);
      mem[i]  = gold[i];
    end
  endtask

  task automatic check_buffer(input string rq);
    int bad = 0;
    for (int i = 0; i < NBYTES; i++) if (mem[i] !== gold[i]) bad++;
    chk(bad == 0, rq, bad, 0);
  endtask

  // exp_work: 2 per applied pair + 1 per skipped pair (0 for clean/fail)
  task automatic run(input logic [2:0] code, input logic [39:0] locs,
                     input logic [31:0] pats, input int exp_work,
                     input bit exp_pass, input int exp_acc, input string rq);
    int lat = 1;
    int acc = 0;
    int nobusy = 0;
    @(negedge clk);
    err_code = code; err_loc = locs; err_pat = pats; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 100) begin
      if (ram_en) acc++;
      if (!busy) nobusy++;
      if (poke_start && lat == 2) begin
        err_code = 3'd7; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(lat == exp_work + 1, {rq, " done latency"}, lat, exp_work + 1);
    chk(pass == exp_pass, {rq, " pass"}, int'(pass), int'(exp_pass));
    chk(acc == exp_acc, {rq, " ram accesses"}, acc, exp_acc);
    chk(nobusy == 0 && !busy, {rq, " busy window"}, nobusy, 0);
    @(negedge clk);
    chk(!done, {rq, " done pulse width"}, int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'h5EC7_0A11));
    fill_random();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !pass && !ram_en && !ram_we, "R1", int'(busy|done|pass|ram_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !ram_en, "R1 after release", int'(busy|done|ram_en), 0);

    // R2 clean code, garbage pairs must not touch buffer
    run(3'd4, {10'd20, 10'd100, 10'd300, 10'd500}, 32'hFFFF_FFFF, 0, 1'b1, 0, "R2");
    check_buffer("R2 buffer untouched");

    // R3 uncorrectable
    run(3'd7, {10'd20, 10'd100, 10'd300, 10'd500}, 32'hA5A5_A5A5, 0, 1'b0, 0, "R3");
    check_buffer("R3 buffer untouched");

    // R4 codes 5 and 6
    run(3'd5, {10'd20, 10'd100, 10'd300, 10'd500}, 32'h1234_5678, 0, 1'b0, 0, "R4 code5");
    run(3'd6, {10'd20, 10'd100, 10'd300, 10'd500}, 32'h1234_5678, 0, 1'b0, 0, "R4 code6");
    check_buffer("R4 buffer untouched");

    // R6 edge offsets 0 and 511 (locations 0x207 and 8)
    mem[0]   = gold[0]   ^ 8'h81;
    mem[511] = gold[511] ^ 8'h3C;
    run(3'd1, {20'd0, loc_of(511), loc_of(0)}, {16'h0, 8'h3C, 8'h81}, 4, 1'b1, 4, "R6 edges");
    check_buffer("R6 edge bytes restored");

    // R7 parity locations skipped: pair1 loc 3 (offset 516), pair2 loc 0x3FF
    mem[40]  = gold[40]  ^ 8'h11;
    mem[300] = gold[300] ^ 8'h22;
    run(3'd3, {loc_of(300), 10'h3FF, 10'd3, loc_of(40)}, {8'h22, 8'hFF, 8'hFF, 8'h11},
        6, 1'b1, 4, "R7 parity skip");
    check_buffer("R7 payload restored, nothing else written");

    // R10 start ignored while busy (a code-7 start arrives mid-run)
    mem[77] = gold[77] ^ 8'h5A;
    poke_start = 1'b1;
    run(3'd0, {30'h0, loc_of(77)}, {24'h0, 8'h5A}, 2, 1'b1, 2, "R10");
    poke_start = 1'b0;
    check_buffer("R10 restored");

    // R5 R6 R8 R9 random 1..4 errors, unused pairs carry junk
    for (int t = 0; t < 40; t++) begin
      int k = 1 + int'($urandom % 4);
      int offs [4];
      logic [39:0] locs = 40'($urandom) ^ {$urandom, 8'h0};
      logic [31:0] pats = $urandom;
      for (int i = 0; i < k; i++) begin
        bit dup;
        do begin
          offs[i] = int'($urandom % NBYTES);
          dup = 1'b0;
          for (int j = 0; j < i; j++) if (offs[j] == offs[i]) dup = 1'b1;
        end while (dup);
        pats[i*8 +: 8] = 8'(1 + ($urandom % 255));
        locs[i*10 +: 10] = loc_of(offs[i]);
        mem[offs[i]] = gold[offs[i]] ^ pats[i*8 +: 8];
      end
      run(3'(k - 1), locs, pats, 2 * k, 1'b1, 2 * k, "R5 R9 random");
      check_buffer("R6 R8 random restored");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule